// File: doc/BRIEF.md
# Two-Wire Dual Wiper Register Writer

This block is the write side of the serial control port of a two-channel digital potentiometer. It listens to a two-wire bus (clock and data lines, both open-drain with pull-ups), samples both lines into the system clock domain, and receives a three-byte command: a device address, an instruction byte and a data byte. It pulls the data line low to acknowledge each byte it accepts.

The instruction byte names the target channel and says whether the write is volatile or nonvolatile. A volatile write changes only the channel's wiper register. A nonvolatile write changes both the wiper register and the channel's shadow register, which stands in for nonvolatile storage. The first channel has 100 taps and the second has 256. A data value above a channel's top tap is held at the top tap. A reload input copies both shadow registers into their wiper registers, as a power cycle would. A write takes effect only when the write-enable input is set and the sequence is closed by a STOP.

Top module: `dual_wiper_tw_writer`

## Requirements
- R1: After each accepted byte, `sda_pull_o` is high during the ninth (acknowledge) SCL clock and low again after that clock's falling edge.
- R2: Only the address byte 0xAE is acknowledged. For any other address, no acknowledge follows that byte or the bytes after it, and no register changes.
- R3: `wen_latch_i` is sampled when the data byte is latched. If it is 0, every wiper and shadow register keeps its value.
- R4: Instruction bit 0 selects the channel (0 = channel A, 1 = channel B). Bits 6..2 must equal 00010 and bit 1 must be 0. Any other instruction is not acknowledged and changes nothing.
- R5: When instruction bit 7 is 0, only the selected wiper register is written and its shadow register is left unchanged.
- R6: When instruction bit 7 is 1, both the selected wiper register and its shadow register receive the value.
- R7: Channel B takes the data byte unchanged (0x00 to 0xFF). Successive writes may carry any values, with no step limit between them.
- R8: Channel A uses straight binary with a top tap of 99 (0x63). Data bytes 0x64 to 0xFF give 0x63, never a wrapped value.
- R9: A one-cycle pulse on `reload_i` copies each shadow register into its wiper register on the next clock edge.
- R10: A START that arrives before a full command has been acknowledged and stopped abandons the command, and no register changes.
- R11: The registers keep their old values after the data byte is acknowledged. They are updated only when the STOP that follows is detected.
- R12: If a reload and a write commit fall in the same clock cycle, the wipers take the previous shadow values, while a nonvolatile commit still writes its shadow register.
- R13: After reset, all four registers read 0 and `sda_pull_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | High to pull the data line low (acknowledge) |
| wen_latch_i | input | 1 | Write-enable latch state from the status register |
| reload_i | input | 1 | Copy shadow registers into wipers (power-up restore) |
| wiper_a_o | output | 8 | Channel A wiper position |
| wiper_b_o | output | 8 | Channel B wiper position |
| nvreg_a_o | output | 8 | Channel A shadow (nonvolatile) value |
| nvreg_b_o | output | 8 | Channel B shadow (nonvolatile) value |

## Verification
The power-up reload and a write commit at STOP can both land on the wiper registers in the same clock cycle. The bench provokes this by counting the two synchronizer stages and the edge register from its own rising data edge during STOP, then raising `reload_i` for exactly the cycle in which the commit is registered, during a nonvolatile write to channel A. Afterwards it expects channel A's wiper to hold the old shadow value and the shadow register to hold the new data. If commit took priority instead, the wiper would hold the new data.

// File: rtl/tw_wiper_pkg.sv
package tw_wiper_pkg;

  localparam int          DATA_W      = 8;
  localparam int          NUM_CH      = 2;
  localparam logic [7:0]  DEV_ADDR    = 8'hAE;
  localparam logic [4:0]  INSTR_FIXED = 5'b00010;
  localparam logic [7:0]  CH_A_TOP    = 8'd99;
  localparam logic [7:0]  CH_B_TOP    = 8'd255;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ACK_A, S_INSTR, S_ACK_I, S_DATA, S_ACK_D, S_DONE, S_IGNORE
  } rx_state_e;

  // highest legal tap of a channel
  function automatic logic [7:0] top_tap(input logic ch);
    return ch ? CH_B_TOP : CH_A_TOP;
  endfunction

  // saturate an incoming byte to the channel's tap range
  function automatic logic [7:0] clamp_tap(input logic ch, input logic [7:0] d);
    return (d > top_tap(ch)) ? top_tap(ch) : d;
  endfunction

  // fixed bits must match and the reserved select bit must be clear
  function automatic logic instr_ok(input logic [7:0] b);
    return (b[6:2] == INSTR_FIXED) && !b[1];
  endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  localparam int LAST = STAGES - 1;

  logic [STAGES:0] scl_sh;
  logic [STAGES:0] sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[LAST:0], scl_i};
      sda_sh <= {sda_sh[LAST:0], sda_i};
    end
  end

  logic scl_cur, scl_prv, sda_cur, sda_prv;
  assign scl_cur = scl_sh[LAST];
  assign scl_prv = scl_sh[STAGES];
  assign sda_cur = sda_sh[LAST];
  assign sda_prv = sda_sh[STAGES];

  assign sda_q     = sda_cur;
  assign scl_rise  = scl_cur && !scl_prv;
  assign scl_fall  = !scl_cur && scl_prv;
  assign start_evt = scl_cur && scl_prv && sda_prv && !sda_cur;
  assign stop_evt  = scl_cur && scl_prv && !sda_prv && sda_cur;

endmodule

// File: rtl/tw_cmd_rx.sv
module tw_cmd_rx
  import tw_wiper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              wen_latch_i,
  output logic              ack_oe,
  output logic              commit,
  output logic              cmd_ch,
  output logic              cmd_wt,
  output logic [DATA_W-1:0] cmd_data
);

  rx_state_e         st;
  logic [DATA_W-1:0] sh;
  logic [3:0]        cnt;
  logic              pend_ok;
  logic              byte_done;
  logic              byte_ok;

  assign byte_done = scl_fall && (cnt == 4'd8);

  always_comb begin
    case (st)
      S_ADDR:  byte_ok = (sh == DEV_ADDR);
      S_INSTR: byte_ok = instr_ok(sh);
      default: byte_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sh       <= '0;
      cnt      <= '0;
      ack_oe   <= 1'b0;
      pend_ok  <= 1'b0;
      cmd_ch   <= 1'b0;
      cmd_wt   <= 1'b0;
      cmd_data <= '0;
    end else if (start_evt) begin
      st      <= S_ADDR;
      cnt     <= '0;
      ack_oe  <= 1'b0;
      pend_ok <= 1'b0;
    end else if (stop_evt) begin
      st      <= S_IDLE;
      ack_oe  <= 1'b0;
      pend_ok <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_INSTR, S_DATA: begin
          if (scl_rise) begin
            sh  <= {sh[DATA_W-2:0], sda_q};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            cnt <= '0;
            if (byte_ok) begin
              ack_oe <= 1'b1;
              case (st)
                S_ADDR:  st <= S_ACK_A;
                S_INSTR: begin
                  st     <= S_ACK_I;
                  cmd_ch <= sh[0];
                  cmd_wt <= sh[7];
                end
                default: st <= S_ACK_D;
              endcase
            end else begin
              st <= S_IGNORE;
            end
          end
        end
        S_ACK_A: if (scl_fall) begin ack_oe <= 1'b0; st <= S_INSTR; end
        S_ACK_I: if (scl_fall) begin ack_oe <= 1'b0; st <= S_DATA; end
        S_ACK_D: begin
          if (scl_rise) begin
            cmd_data <= sh;
            pend_ok  <= wen_latch_i;
          end else if (scl_fall) begin
            ack_oe <= 1'b0;
            st     <= S_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign commit = stop_evt && (st == S_DONE) && pend_ok;

  AST_ADDR_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && byte_done && sh != DEV_ADDR && !start_evt && !stop_evt)
      |=> (!ack_oe && st == S_IGNORE)); // R2

  AST_RSVD_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_INSTR && byte_done && sh[1] && !start_evt && !stop_evt)
      |=> (!ack_oe && st == S_IGNORE)); // R4

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && scl_fall) |=> !ack_oe); // R1

endmodule

// File: rtl/tw_wiper_bank.sv
module tw_wiper_bank
  import tw_wiper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              cmd_ch,
  input  logic              cmd_wt,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              reload_i,
  output logic [DATA_W-1:0] wiper_q [NUM_CH],
  output logic [DATA_W-1:0] nv_q    [NUM_CH]
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic CH_ID = 1'(g);

    logic              sel;
    logic [DATA_W-1:0] tap;

    assign sel = commit && (cmd_ch == CH_ID);
    assign tap = clamp_tap(CH_ID, cmd_data);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wiper_q[g] <= '0;
        nv_q[g]    <= '0;
      end else begin
        if (sel && cmd_wt) nv_q[g] <= tap;
        if (reload_i)      wiper_q[g] <= nv_q[g];
        else if (sel)      wiper_q[g] <= tap;
      end
    end

    AST_VOL_KEEPS_NV: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !cmd_wt) |=> $stable(nv_q[g])); // R5

    AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      reload_i |=> (wiper_q[g] == $past(nv_q[g]))); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && !reload_i) |=> ($stable(wiper_q[g]) && $stable(nv_q[g]))); // R11

    AST_TAP_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
      (wiper_q[g] <= top_tap(CH_ID))); // R8
  end

endmodule

// File: rtl/dual_wiper_tw_writer.sv
module dual_wiper_tw_writer
  import tw_wiper_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              wen_latch_i,
  input  logic              reload_i,
  output logic [DATA_W-1:0] wiper_a_o,
  output logic [DATA_W-1:0] wiper_b_o,
  output logic [DATA_W-1:0] nvreg_a_o,
  output logic [DATA_W-1:0] nvreg_b_o
);

  logic              sda_q, scl_rise, scl_fall, start_evt, stop_evt;
  logic              commit, cmd_ch, cmd_wt;
  logic [DATA_W-1:0] cmd_data;
  logic [DATA_W-1:0] wiper_q [NUM_CH];
  logic [DATA_W-1:0] nv_q    [NUM_CH];

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  tw_cmd_rx u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_q       (sda_q),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .wen_latch_i (wen_latch_i),
    .ack_oe      (sda_pull_o),
    .commit      (commit),
    .cmd_ch      (cmd_ch),
    .cmd_wt      (cmd_wt),
    .cmd_data    (cmd_data)
  );

  tw_wiper_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .cmd_ch   (cmd_ch),
    .cmd_wt   (cmd_wt),
    .cmd_data (cmd_data),
    .reload_i (reload_i),
    .wiper_q  (wiper_q),
    .nv_q     (nv_q)
  );

  assign wiper_a_o = wiper_q[0];
  assign wiper_b_o = wiper_q[1];
  assign nvreg_a_o = nv_q[0];
  assign nvreg_b_o = nv_q[1];

  AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> stop_evt); // R11

endmodule

// File: tb/tb_dual_wiper_tw_writer.sv
module tb_dual_wiper_tw_writer;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int NV = 13;

  // {address, instruction, data, write enable}
  localparam logic [24:0] VEC [NV] = '{
    {8'hAE, 8'h88, 8'h30, 1'b1},  // R6 channel A nonvolatile
    {8'hAE, 8'h89, 8'h0F, 1'b1},  // R6 R7 channel B nonvolatile
    {8'hAE, 8'h08, 8'h50, 1'b1},  // R5 channel A volatile
    {8'hAE, 8'h09, 8'h1C, 1'b1},  // R7 channel B volatile
    {8'hAE, 8'h08, 8'hC8, 1'b1},  // R8 clamp
    {8'hAE, 8'h09, 8'hFF, 1'b1},  // R7 full scale
    {8'hAE, 8'h88, 8'h63, 1'b1},  // R8 exact top
    {8'hAE, 8'h08, 8'h64, 1'b1},  // R8 one over top
    {8'hA6, 8'h08, 8'h11, 1'b1},  // R2 wrong address
    {8'hAE, 8'h0A, 8'h22, 1'b1},  // R4 reserved select
    {8'hAE, 8'h18, 8'h22, 1'b1},  // R4 bad fixed bits
    {8'hAE, 8'h09, 8'h44, 1'b0},  // R3 write disabled
    {8'hAE, 8'h08, 8'h07, 1'b1}   // R7 arbitrary jump
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic wen = 1'b0;
  logic reload = 1'b0;
  logic sda_pull;
  logic sda_line;
  logic [7:0] wa, wb, na, nb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_w [2];
  logic [7:0] m_n [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_drv & ~sda_pull;

  dual_wiper_tw_writer dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .sda_pull_o  (sda_pull),
    .wen_latch_i (wen),
    .reload_i    (reload),
    .wiper_a_o   (wa),
    .wiper_b_o   (wb),
    .nvreg_a_o   (na),
    .nvreg_b_o   (nb)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq(Q);
    scl = 1'b1;     wq(Q);
    sda_drv = 1'b0; wq(Q);
    scl = 1'b0;     wq(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq(Q);
    scl = 1'b1;     wq(Q);
    sda_drv = 1'b1; wq(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_drv = b; wq(Q);
    scl = 1'b1;  wq(Q);
    scl = 1'b0;  wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_drv = 1'b1; wq(Q);
    scl = 1'b1;     wq(Q/2);
    ack = sda_pull;
    wq(Q - Q/2);
    scl = 1'b0;     wq(Q);
  endtask

  task automatic chk_regs(input string req);
    chk({req, " wiper A"}, wa, m_w[0]);
    chk({req, " wiper B"}, wb, m_w[1]);
    chk({req, " shadow A"}, na, m_n[0]);
    chk({req, " shadow B"}, nb, m_n[1]);
  endtask

  function automatic logic [7:0] model_tap(input logic ch, input logic [7:0] d);
    if (ch) return d;
    if (d >= 8'd100) return 8'd99;
    return d;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2;
    logic [7:0] addr, ins, dat;
    logic ea, ei, ch;
    m_w = '{8'h00, 8'h00};
    m_n = '{8'h00, 8'h00};
    wq(5);
    // R13 reset state
    chk("R13 pull", {7'b0, sda_pull}, 8'h00);
    chk_regs("R13");
    rst_n = 1'b1;
    wq(5);

    foreach (VEC[k]) begin
      {addr, ins, dat, wen} = VEC[k];
      ea = (addr == 8'hAE);
      ei = ea && (ins[6:2] == 5'b00010) && (ins[1] == 1'b0);
      bus_start();
      send_byte(addr, a0);
      send_byte(ins, a1);
      send_byte(dat, a2);
      chk("R1 R2 address ack", {7'b0, a0}, {7'b0, ea});
      chk("R4 instruction ack", {7'b0, a1}, {7'b0, ei});
      chk("R1 data ack", {7'b0, a2}, {7'b0, ei});
      if (k == 0) chk_regs("R11 before stop");
      bus_stop();
      if (ei && wen) begin
        ch = ins[0];
        m_w[ch] = model_tap(ch, dat);
        if (ins[7]) m_n[ch] = model_tap(ch, dat);
      end
      chk_regs("R2 R3 R4 R5 R6 R7 R8 vector");
      chk("R1 pull idle", {7'b0, sda_pull}, 8'h00);
    end

    // R9 reload copies shadow to wiper
    reload = 1'b1; wq(1); reload = 1'b0; wq(1);
    m_w[0] = m_n[0];
    m_w[1] = m_n[1];
    chk_regs("R9 reload");

    // R10 START inside the data byte abandons the command
    wen = 1'b1;
    bus_start();
    send_byte(8'hAE, a0);
    send_byte(8'h89, a1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_start();
    bus_stop();
    chk_regs("R10 abort");

    // R12 reload in the commit cycle of a nonvolatile write to channel A
    bus_start();
    send_byte(8'hAE, a0);
    send_byte(8'h88, a1);
    send_byte(8'h21, a2);
    sda_drv = 1'b0; wq(Q);
    scl = 1'b1;     wq(Q);
    sda_drv = 1'b1;       // rising data edge, then two sync stages and edge register
    wq(2);
    reload = 1'b1;
    wq(1);
    reload = 1'b0;
    wq(2*Q);
    m_w[0] = m_n[0];
    m_w[1] = m_n[1];
    m_n[0] = 8'h21;
    chk_regs("R12 reload with commit");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule